// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into a stream of column addresses, one per clock, for a synchronous DRAM style memory. A request carries a start column, a three-bit length code, an ordering bit, a direction bit and a single-location-write bit. From the clock after the request the block presents one column on each cycle. It flags the final beat, and it stops when the burst ends, when a terminate input arrives, or when a new request replaces the current one.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The upper column bits stay fixed. The low bits either count upward and wrap, or are the start value XORed with the beat number. Page mode walks the whole row sequentially, wraps at the end and has no last beat. It runs until a terminate or a new request. A configuration that cannot be honoured is served as a one-beat access, and an error flag is raised for it.

Top module: `burst_col_gen`

## Requirements
- R1: After a synchronous reset, `beat_vld_o`, `beat_last_o` and `cfg_err_o` are 0 and `col_o` is 0.
- R2: When `req_i` is sampled high at a clock edge, the block shows beat 0 in the next cycle: `beat_vld_o`=1 and `col_o` equals the sampled `req_col_i`.
- R3: The length code `len_sel_i` is decoded as 000=1, 001=2, 010=4, 011=8 and 111=whole page. A fixed burst holds `beat_vld_o` high for exactly that many consecutive cycles.
- R4: With `order_i`=0, beat i of a fixed burst of length L keeps the column bits above log2(L) from the start column. Its low log2(L) bits are (start low bits + i) mod L.
- R5: With `order_i`=1, beat i of a fixed burst of length L keeps the upper bits, and its low log2(L) bits are the start low bits XOR i.
- R6: With length code 000, `order_i` has no effect: one beat at the start column.
- R7: Page mode (111 with `order_i`=0) outputs (start + i) mod 2^COL_W on beat i and never asserts `beat_last_o`.
- R8: `beat_last_o` is 1 exactly on the final beat of a fixed-length burst.
- R9: `stop_i` sampled high while a beat is shown, with `req_i` low, makes `beat_vld_o` and `beat_last_o` 0 in the next cycle. `stop_i` has no effect while idle.
- R10: A request during a burst abandons it, and the next cycle shows beat 0 of the new request. A request and `stop_i` in the same cycle start the new burst.
- R11: With `wr_i`=1 and `wr_single_i`=1 the burst is one beat long whatever the length code. With `wr_i`=0 the `wr_single_i` bit has no effect.
- R12: A reserved length code (100, 101, 110), or page mode with `order_i`=1, gives a one-beat burst at the start column. `cfg_err_o` goes to 1 with beat 0 and holds until the next request with a valid configuration clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start pulse for a new burst |
| req_col_i | input | COL_W | Start column |
| len_sel_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| wr_i | input | 1 | Request is a write |
| wr_single_i | input | 1 | Writes use a single location |
| stop_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Last request had an unusable configuration |

## Verification
The assertions assume that `req_i` is the only input that loads a new configuration. Between requests, `len_sel_i`, `order_i`, `wr_i` and `wr_single_i` are don't-care, so the stimulus changes them freely outside request cycles. They also assume the column stays within COL_W bits. The checks on block alignment therefore apply only to fixed bursts, and page mode is free to cross any boundary. The stimulus pulses `stop_i` both while idle and during bursts. It places requests on the last beat, in the middle of a burst and together with `stop_i`, which covers every case the priority rules name.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  typedef struct packed {
    logic       page;   // whole-row sequential burst
    logic [1:0] lg;     // log2 of fixed length
    logic       ilv;    // interleaved ordering
    logic       err;    // configuration not usable
  } burst_cfg_t;
endpackage

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode
  import colgen_pkg::*;
(
  input  logic [2:0]  len_sel_i,
  input  logic        order_i,
  input  logic        wr_i,
  input  logic        wr_single_i,
  output burst_cfg_t  cfg_o
);
  logic       page_raw;
  logic [1:0] lg_raw;
  logic       bad_code;
  logic       bad_mix;

  always_comb begin
    page_raw = 1'b0;
    lg_raw   = 2'd0;
    bad_code = 1'b0;
    case (len_sel_i)
      LEN_1:    lg_raw = 2'd0;
      LEN_2:    lg_raw = 2'd1;
      LEN_4:    lg_raw = 2'd2;
      LEN_8:    lg_raw = 2'd3;
      LEN_PAGE: page_raw = 1'b1;
      default:  bad_code = 1'b1;
    endcase
    bad_mix = page_raw & order_i;
  end

  always_comb begin
    cfg_o.err  = bad_code | bad_mix;
    cfg_o.page = page_raw & ~bad_mix & ~(wr_i & wr_single_i);
    cfg_o.lg   = (bad_code | (wr_i & wr_single_i)) ? 2'd0 : lg_raw;
    cfg_o.ilv  = order_i & ~page_raw;
  end
endmodule

// File: rtl/colgen_addr_form.sv
module colgen_addr_form #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [1:0]       lg_i,
  input  logic             page_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  localparam int FIX_BITS = 3;

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] col_seq;
  logic [COL_W-1:0] col_ilv;

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < FIX_BITS) begin : g_low
      assign wrap_mask[b] = page_i | (lg_i > 2'(b));
    end else begin : g_high
      assign wrap_mask[b] = page_i;
    end
  end

  always_comb begin
    sum     = base_i + beat_i;
    col_seq = (base_i & ~wrap_mask) | (sum & wrap_mask);
    col_ilv = base_i ^ (beat_i & wrap_mask);
    col_o   = ilv_i ? col_ilv : col_seq;
  end
endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [COL_W-1:0] req_col_i,
  input  burst_cfg_t       cfg_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_next_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_next_o,
  output logic [1:0]       lg_o,
  output logic             page_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] col_o,
  output logic             vld_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q, beat_q, col_q;
  logic [1:0]       lg_q;
  logic             page_q, ilv_q, vld_q, last_q, err_q;
  logic             advance;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] final_beat;

  always_comb begin
    advance  = vld_q & ~stop_i & (page_q | ~last_q);
    beat_nxt = beat_q + COL_W'(1);
    case (lg_q)
      2'd0:    final_beat = COL_W'(0);
      2'd1:    final_beat = COL_W'(1);
      2'd2:    final_beat = COL_W'(3);
      default: final_beat = COL_W'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      col_q  <= '0;
      lg_q   <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (req_i) begin
      base_q <= req_col_i;
      beat_q <= '0;
      col_q  <= req_col_i;
      lg_q   <= cfg_i.lg;
      page_q <= cfg_i.page;
      ilv_q  <= cfg_i.ilv;
      err_q  <= cfg_i.err;
      vld_q  <= 1'b1;
      last_q <= ~cfg_i.page & (cfg_i.lg == 2'd0);
    end else if (advance) begin
      beat_q <= beat_nxt;
      col_q  <= col_next_i;
      last_q <= ~page_q & (beat_nxt == final_beat);
    end else if (vld_q) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end
  end

  assign base_o      = base_q;
  assign beat_next_o = beat_nxt;
  assign lg_o        = lg_q;
  assign page_o      = page_q;
  assign ilv_o       = ilv_q;
  assign col_o       = col_q;
  assign vld_o       = vld_q;
  assign last_o      = last_q;
  assign err_o       = err_q;

  // R7
  page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && page_q) |-> !last_q);

  // R4
  block_upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !req_i && !page_q) |=> col_q[COL_W-1:3] == $past(col_q[COL_W-1:3]));

  // R3
  fixed_len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !page_q && !req_i) |-> (beat_q <= final_beat));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [2:0]       len_sel_i,
  input  logic             order_i,
  input  logic             wr_i,
  input  logic             wr_single_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o,
  output logic             cfg_err_o
);
  burst_cfg_t       cfg;
  logic [COL_W-1:0] base, beat_next, col_next;
  logic [1:0]       lg;
  logic             page, ilv;

  colgen_cfg_decode u_dec (
    .len_sel_i   (len_sel_i),
    .order_i     (order_i),
    .wr_i        (wr_i),
    .wr_single_i (wr_single_i),
    .cfg_o       (cfg)
  );

  colgen_addr_form #(.COL_W(COL_W)) u_form (
    .base_i (base),
    .beat_i (beat_next),
    .lg_i   (lg),
    .page_i (page),
    .ilv_i  (ilv),
    .col_o  (col_next)
  );

  colgen_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .req_col_i   (req_col_i),
    .cfg_i       (cfg),
    .stop_i      (stop_i),
    .col_next_i  (col_next),
    .base_o      (base),
    .beat_next_o (beat_next),
    .lg_o        (lg),
    .page_o      (page),
    .ilv_o       (ilv),
    .col_o       (col_o),
    .vld_o       (beat_vld_o),
    .last_o      (beat_last_o),
    .err_o       (cfg_err_o)
  );

  // R2
  req_loads_start_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (beat_vld_o && col_o == $past(req_col_i)));

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && stop_i && !req_i) |=> (!beat_vld_o && !beat_last_o));

  // R8
  last_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    beat_last_o |-> beat_vld_o);

  // R8
  last_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_last_o && !req_i) |=> !beat_vld_o);

  // R12
  err_single_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && cfg_err_o) |-> beat_last_o);
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_i = 1'b0;
  logic [COL_W-1:0] req_col_i = '0;
  logic [2:0]       len_sel_i = '0;
  logic             order_i = 1'b0;
  logic             wr_i = 1'b0;
  logic             wr_single_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             beat_vld_o, beat_last_o, cfg_err_o;

  burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (.*);

  always #2.5 clk = ~clk;

  int    vectors = 0, miscompares = 0, cycles = 0;
  bit    chk_en = 0;
  string cur_req = "R1";

  // reference model state
  int m_base, m_i, m_len;
  bit m_ilv, m_bad;
  bit e_vld, e_last, e_err;
  int e_col;

  function automatic int ref_col(int base, int i, int len, bit ilv);
    if (len == 0) return (base + i) % PAGE;
    if (ilv) return base ^ i;
    return (base / len) * len + ((base % len + i) % len);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      e_vld = 0; e_last = 0; e_err = 0; e_col = 0;
    end else if (req_i) begin
      m_bad = 0;
      case (len_sel_i)
        3'd0: m_len = 1;
        3'd1: m_len = 2;
        3'd2: m_len = 4;
        3'd3: m_len = 8;
        3'd7: m_len = 0;
        default: begin m_len = 1; m_bad = 1; end
      endcase
      if (m_len == 0 && order_i) begin m_len = 1; m_bad = 1; end
      if (wr_i && wr_single_i) m_len = 1;
      m_base = int'(req_col_i); m_i = 0; m_ilv = order_i;
      e_err = m_bad; e_vld = 1; e_col = m_base; e_last = (m_len == 1);
    end else if (e_vld && stop_i) begin
      e_vld = 0; e_last = 0;
    end else if (e_vld && (m_len == 0 || !e_last)) begin
      m_i++;
      e_col  = ref_col(m_base, m_i, m_len, m_ilv);
      e_last = (m_len != 0) && (m_i == m_len - 1);
    end else begin
      e_vld = 0; e_last = 0;
    end
    if (rst) chk_en = 1;
  end

  always @(negedge clk) begin
    if (chk_en) begin
      vectors++;
      if (beat_vld_o !== e_vld || beat_last_o !== e_last || cfg_err_o !== e_err ||
          (e_vld && int'(col_o) != e_col) || (cur_req == "R1" && col_o !== '0)) begin
        miscompares++;
        $display("FAIL %s cyc %0d: vld/last/err/col act %b/%b/%b/%0d exp %b/%b/%b/%0d",
                 cur_req, cycles, beat_vld_o, beat_last_o, cfg_err_o, col_o,
                 e_vld, e_last, e_err, e_col);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: act hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic drive(bit rq, int c, int code, bit il, bit w, bit sg, bit st);
    @(negedge clk);
    req_i = rq; req_col_i = COL_W'(c); len_sel_i = 3'(code);
    order_i = il; wr_i = w; wr_single_i = sg; stop_i = st;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 5, 1, 1, 1, 0);
  endtask

  task automatic burst(int c, int code, bit il, bit w, bit sg, int run);
    drive(1, c, code, il, w, sg, 0);
    idle(run);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    cur_req = "R2";  burst(13, 0, 0, 0, 0, 3);
    cur_req = "R3";  burst(0, 1, 0, 0, 0, 4); burst(0, 2, 0, 0, 0, 6); burst(0, 3, 0, 0, 0, 10);
    cur_req = "R4";  burst(5, 3, 0, 0, 0, 10); burst(10'h3F6, 2, 0, 0, 0, 6); burst(7, 1, 0, 0, 0, 4);
    cur_req = "R5";  burst(5, 3, 1, 0, 0, 10); burst(10'h12E, 2, 1, 0, 0, 6); burst(3, 1, 1, 0, 0, 4);
    cur_req = "R6";  burst(99, 0, 1, 0, 0, 3);
    cur_req = "R7";  burst(10'h3FC, 7, 0, 0, 0, 12); drive(0, 0, 0, 0, 0, 0, 1); idle(3);
    cur_req = "R8";  burst(6, 3, 0, 1, 0, 10); drive(1, 2, 2, 0, 0, 0, 0); idle(2);
    drive(1, 9, 1, 0, 0, 0, 0); idle(1); drive(1, 20, 1, 1, 0, 0, 0); idle(4);
    cur_req = "R9";  burst(40, 3, 0, 0, 0, 3); drive(0, 0, 0, 0, 0, 0, 1); idle(3);
    drive(0, 0, 0, 0, 0, 0, 1); idle(2);
    cur_req = "R10"; burst(16, 3, 0, 0, 0, 3); drive(1, 33, 2, 1, 0, 0, 0); idle(1);
    drive(1, 50, 3, 0, 0, 0, 1); idle(10);
    cur_req = "R11"; burst(70, 3, 0, 1, 1, 3); burst(74, 2, 0, 0, 1, 6); burst(75, 7, 0, 1, 1, 3);
    cur_req = "R12"; burst(81, 5, 0, 0, 0, 3); burst(82, 7, 1, 0, 0, 3); burst(83, 4, 1, 0, 0, 2);
    burst(84, 6, 0, 0, 0, 1); burst(85, 2, 0, 0, 0, 6);
    cur_req = "R3";
    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = (k * 7) % 6;
      drive((k % 3) == 0, (k * 37) % PAGE, (sel == 5) ? 7 : ((sel == 4) ? 6 : sel),
            (k % 4) == 1, (k % 5) == 2, (k % 7) == 3, (k % 11) == 5);
    end
    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule